// File: doc/BRIEF.md
# I2C Slave Controller with 7-bit and 10-bit Addressing

This block is a target-side controller for a two-wire serial bus with open-drain clock and data lines. It oversamples both lines with the system clock and detects start, stop and repeated-start conditions. Each address byte is compared against a programmable 10-bit own address. A configuration bit selects 7-bit matching, which uses the low seven bits of that address, or 10-bit matching, which needs two address bytes.

Bytes written by the bus controller are shifted in and copied into a single receive holding register. Every byte that is accepted there raises a one-cycle interrupt pulse. For read transfers the byte to send sits in one transmit register and is shifted out of it directly. Before each byte it sends, the slave holds SCL low. It lets SCL go only when the host pulses a clock-release input, which gives the host time to load that register. Read-only status outputs report whether the slave is addressed, the transfer direction, whether the last byte was address or data, and a sticky overflow flag.

Top module: `i2cs_slave`

## Requirements
- R1: After reset, scl_oe, sda_oe, rx_full, irq, st_addressed, st_read, st_data and st_ovf are all 0.
- R2: With cfg_ten_bit=0, the slave ACKs a first byte after a start whose bits [7:1] equal cfg_own_addr[6:0]. It then sets st_addressed, and st_read takes bit 0 of that byte (1 = read). Any other first byte is NACKed.
- R3: With cfg_ten_bit=1, a first byte equal to 11110, then cfg_own_addr[9:8], then 0 is ACKed without setting st_addressed. A second byte equal to cfg_own_addr[7:0] is then ACKed and sets st_addressed with st_read=0. A mismatch on either byte is NACKed and leaves st_addressed at 0.
- R4: With cfg_ten_bit=1, after a repeated start that follows a full two-byte match, a single byte of 11110, then cfg_own_addr[9:8], then 1 is ACKed and sets st_addressed with st_read=1. The same byte after a stop is NACKed.
- R5: A data byte received while rx_full=0 is ACKed and appears on rx_rdata. rx_full rises, and irq pulses high for exactly one cycle. rx_rd clears rx_full.
- R6: A data byte that completes while rx_full=1 is NACKed. In that case st_ovf sets and stays set until ovf_clr, and rx_rdata keeps the earlier byte.
- R7: In a read transfer the slave holds SCL low after each ACKed read address and after each data byte the controller ACKs. It frees SCL only after a clk_rel pulse. Bytes go out MSB first from the register last written through tx_wr.
- R8: The slave changes its SDA drive only while SCL is low. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high.
- R9: st_data is 0 after an address byte and 1 after a data byte. A stop clears st_addressed.
- R10: Bytes that are not addressed to the slave produce no ACK, no irq and no change of rx_full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_own_addr | input | 10 | Own slave address |
| cfg_ten_bit | input | 1 | 1 selects 10-bit address matching |
| tx_wdata | input | 8 | Byte for the transmit register |
| tx_wr | input | 1 | Write strobe for the transmit register |
| rx_rdata | output | 8 | Receive holding register |
| rx_rd | input | 1 | Pop strobe, clears rx_full |
| rx_full | output | 1 | Receive holding register occupied |
| irq | output | 1 | One-cycle pulse per accepted received byte |
| clk_rel | input | 1 | Clock-release pulse ending a stretch |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| st_addressed | output | 1 | Slave currently addressed |
| st_read | output | 1 | Direction of current transfer, 1 = read |
| st_data | output | 1 | Last byte was data (1) or address (0) |
| st_ovf | output | 1 | Sticky receive overflow |

## Verification
A corrupted shift register or bit counter shows up at the ports within the same byte. The ACK slot, at the ninth SCL pulse, then carries the wrong level, or rx_rdata holds a shifted value once the byte ends. A lost 10-bit match flag or direction flag is visible at the next address byte, where the repeated-start read is NACKed or SCL is not stretched. A stuck-full receive register is seen at the very next data byte, which is NACKed with st_ovf raised.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int HI_W   = ADDR_W - BYTE_W;

  typedef enum logic [3:0] {
    S_IDLE, S_ADR1, S_ADR2, S_RXD, S_ACK, S_HOLD, S_TXD, S_TXACK, S_WAIT
  } st_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_rxbuf.sv
module i2cs_rxbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         ovf_clr,
  output logic [W-1:0] data,
  output logic         full,
  output logic         ovf,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      full <= 1'b0;
      ovf  <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (pop)     full <= 1'b0;
      if (ovf_clr) ovf  <= 1'b0;
      if (push) begin
        if (!full) begin
          data <= push_data;
          full <= 1'b1;
          irq  <= 1'b1;
        end else begin
          ovf <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] cfg_own_addr,
  input  logic              cfg_ten_bit,
  input  logic [BYTE_W-1:0] tx_wdata,
  input  logic              tx_wr,
  output logic [BYTE_W-1:0] rx_rdata,
  input  logic              rx_rd,
  output logic              rx_full,
  output logic              irq,
  input  logic              clk_rel,
  input  logic              ovf_clr,
  output logic              st_addressed,
  output logic              st_read,
  output logic              st_data,
  output logic              st_ovf
);
  localparam logic [3:0] BITS = 4'(BYTE_W);
  localparam logic [4:0] TEN_HDR = 5'b11110;

  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_ev, stop_ev;

  i2cs_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_i({scl_i, sda_i}), .sync_o(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2cs_bus_events u_ev (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  st_t               state, nxt;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg, tx_reg, push_data;
  logic              push, hi_match, m_ack;

  i2cs_rxbuf #(.W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data),
    .pop(rx_rd), .ovf_clr(ovf_clr), .data(rx_rdata),
    .full(rx_full), .ovf(st_ovf), .irq(irq)
  );

  // Address comparators on the completed byte
  logic m7, m10hi, m10lo;
  assign m7    = shreg[BYTE_W-1:1] == cfg_own_addr[BYTE_W-2:0];
  assign m10hi = (shreg[7:3] == TEN_HDR) && (shreg[2:1] == cfg_own_addr[ADDR_W-1:BYTE_W]);
  assign m10lo = shreg == cfg_own_addr[BYTE_W-1:0];

  logic [2:0] tx_idx;
  assign tx_idx = 3'd6 - bit_cnt[2:0];

  logic byte_done;
  assign byte_done = scl_fall && (bit_cnt == BITS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      nxt          <= S_IDLE;
      bit_cnt      <= '0;
      shreg        <= '0;
      tx_reg       <= '0;
      push         <= 1'b0;
      push_data    <= '0;
      hi_match     <= 1'b0;
      m_ack        <= 1'b0;
      sda_oe       <= 1'b0;
      scl_oe       <= 1'b0;
      st_addressed <= 1'b0;
      st_read      <= 1'b0;
      st_data      <= 1'b0;
    end else begin
      push <= 1'b0;
      if (tx_wr) tx_reg <= tx_wdata;

      if (stop_ev) begin
        state        <= S_IDLE;
        sda_oe       <= 1'b0;
        scl_oe       <= 1'b0;
        st_addressed <= 1'b0;
        hi_match     <= 1'b0;
      end else if (start_ev) begin
        state        <= S_ADR1;
        bit_cnt      <= '0;
        sda_oe       <= 1'b0;
        scl_oe       <= 1'b0;
        st_addressed <= 1'b0;
      end else begin
        unique case (state)
          S_ADR1, S_ADR2, S_RXD: begin
            if (scl_rise && bit_cnt < BITS) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              bit_cnt <= '0;
              if (state == S_ADR1) begin
                if (!cfg_ten_bit && m7) begin
                  sda_oe       <= 1'b1;
                  state        <= S_ACK;
                  nxt          <= shreg[0] ? S_HOLD : S_RXD;
                  st_addressed <= 1'b1;
                  st_read      <= shreg[0];
                  st_data      <= 1'b0;
                end else if (cfg_ten_bit && m10hi && !shreg[0]) begin
                  sda_oe   <= 1'b1;
                  state    <= S_ACK;
                  nxt      <= S_ADR2;
                  st_data  <= 1'b0;
                  hi_match <= 1'b0;
                end else if (cfg_ten_bit && m10hi && shreg[0] && hi_match) begin
                  sda_oe       <= 1'b1;
                  state        <= S_ACK;
                  nxt          <= S_HOLD;
                  st_addressed <= 1'b1;
                  st_read      <= 1'b1;
                  st_data      <= 1'b0;
                end else begin
                  state    <= S_WAIT;
                  hi_match <= 1'b0;
                end
              end else if (state == S_ADR2) begin
                if (m10lo) begin
                  sda_oe       <= 1'b1;
                  state        <= S_ACK;
                  nxt          <= S_RXD;
                  st_addressed <= 1'b1;
                  st_read      <= 1'b0;
                  st_data      <= 1'b0;
                  hi_match     <= 1'b1;
                end else begin
                  state <= S_WAIT;
                end
              end else begin
                st_data   <= 1'b1;
                push      <= 1'b1;
                push_data <= shreg;
                if (!rx_full) begin
                  sda_oe <= 1'b1;
                  state  <= S_ACK;
                  nxt    <= S_RXD;
                end else begin
                  state <= S_WAIT;
                end
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= nxt;
              if (nxt == S_HOLD) scl_oe <= 1'b1;
            end
          end
          S_HOLD: begin
            if (clk_rel) begin
              scl_oe  <= 1'b0;
              state   <= S_TXD;
              bit_cnt <= '0;
              sda_oe  <= ~tx_reg[BYTE_W-1];
            end
          end
          S_TXD: begin
            if (scl_fall) begin
              if (bit_cnt == BITS - 4'd1) begin
                sda_oe  <= 1'b0;
                state   <= S_TXACK;
                st_data <= 1'b1;
              end else begin
                bit_cnt <= bit_cnt + 4'd1;
                sda_oe  <= ~tx_reg[tx_idx];
              end
            end
          end
          S_TXACK: begin
            if (scl_rise) m_ack <= ~sda_s;
            else if (scl_fall) begin
              if (m_ack) begin
                state  <= S_HOLD;
                scl_oe <= 1'b1;
              end else begin
                state <= S_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_slave_chk.sv
module i2cs_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       irq,
  input logic       clk_rel,
  input logic       st_ovf,
  input logic       ovf_clr,
  input logic       rx_full,
  input logic       rx_rd,
  input logic [7:0] rx_rdata,
  input logic       st_read,
  input logic       st_addressed
);
  // R5: interrupt is a single-cycle pulse
  a_r5_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R5: an interrupt always comes with a filled holding register
  a_r5_irq_full: assert property (@(posedge clk) disable iff (rst)
    irq |-> rx_full);

  // R6: overflow flag is sticky until cleared
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    st_ovf && !ovf_clr |=> st_ovf);

  // R6: a full holding register keeps its byte until popped
  a_r6_rx_hold: assert property (@(posedge clk) disable iff (rst)
    rx_full && !rx_rd |=> $stable(rx_rdata));

  // R7: stretching only inside an addressed read transfer
  a_r7_stretch_read: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> (st_read && st_addressed));

  // R7: the stretch ends only on a release pulse
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_oe) |-> $past(clk_rel));

  // R8: the slave moves SDA only while SCL is low
  a_r8_sda_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_i));
endmodule

bind i2cs_slave i2cs_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .irq(irq), .clk_rel(clk_rel), .st_ovf(st_ovf), .ovf_clr(ovf_clr),
  .rx_full(rx_full), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
  .st_read(st_read), .st_addressed(st_addressed)
);

// File: tb/i2cs_slave_tb.sv
module i2cs_slave_tb_top;
  localparam int Q  = 10;
  localparam int WD = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic [9:0] cfg_own_addr = '0;
  logic       cfg_ten_bit = 1'b0;
  logic [7:0] tx_wdata = '0, rx_rdata;
  logic tx_wr = 0, rx_rd = 0, clk_rel = 0, ovf_clr = 0;
  logic rx_full, irq, st_addressed, st_read, st_data, st_ovf;

  assign scl_line = ~(m_scl_low | scl_oe);
  assign sda_line = ~(m_sda_low | sda_oe);

  i2cs_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_own_addr(cfg_own_addr),
    .cfg_ten_bit(cfg_ten_bit), .tx_wdata(tx_wdata), .tx_wr(tx_wr),
    .rx_rdata(rx_rdata), .rx_rd(rx_rd), .rx_full(rx_full), .irq(irq),
    .clk_rel(clk_rel), .ovf_clr(ovf_clr), .st_addressed(st_addressed),
    .st_read(st_read), .st_data(st_data), .st_ovf(st_ovf)
  );

  int tests = 0, fails = 0, irq_cnt = 0;
  always @(posedge clk) if (!rst && irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high;
    int n = 0;
    while (!scl_line && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk("R7 scl never released", 0, 1);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0;
  endtask

  task automatic bus_start;
    m_sda_low = 0; m_scl_low = 0; cyc(Q);
    m_sda_low = 1; cyc(Q);
    m_scl_low = 1; cyc(Q);
  endtask

  task automatic bus_rstart;
    m_sda_low = 0; cyc(Q);
    m_scl_low = 0; wait_high(); cyc(Q);
    m_sda_low = 1; cyc(Q);
    m_scl_low = 1; cyc(Q);
  endtask

  task automatic bus_stop;
    m_sda_low = 1; cyc(Q);
    m_scl_low = 0; wait_high(); cyc(Q);
    m_sda_low = 0; cyc(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda_low = ~b; cyc(Q);
    m_scl_low = 0; wait_high(); cyc(2*Q);
    m_scl_low = 1; cyc(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda_low = 0; cyc(Q);
    m_scl_low = 0; wait_high(); cyc(Q);
    b = sda_line; cyc(Q);
    m_scl_low = 1; cyc(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~ack);
  endtask

  // Controller lets go of SCL; the slave must keep it low (R7)
  task automatic probe_stretch(input string tag);
    m_sda_low = 0; cyc(Q);
    m_scl_low = 0; cyc(40);
    chk(tag, scl_line, 1'b0);
  endtask

  task automatic release_with(input logic [7:0] d);
    tx_wdata = d; pulse(tx_wr);
    pulse(clk_rel);
    wait_high();
  endtask

  // {ten_bit, own_addr[9:0], first byte, expected ack}
  localparam logic [19:0] VEC [8] = '{
    {1'b0, 10'h03A, 8'h74, 1'b1},
    {1'b0, 10'h03A, 8'h76, 1'b0},
    {1'b0, 10'h07F, 8'hFE, 1'b1},
    {1'b1, 10'h2C5, 8'hF4, 1'b1},
    {1'b1, 10'h2C5, 8'hF2, 1'b0},
    {1'b1, 10'h2C5, 8'hF5, 1'b0},
    {1'b1, 10'h0C5, 8'h8A, 1'b0},
    {1'b0, 10'h03A, 8'hF4, 1'b0}
  };

  initial begin
    cyc(WD);
    chk("watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    cyc(4); rst = 1'b0; cyc(2);
    // R1 reset state
    chk("R1 outputs", {scl_oe, sda_oe, rx_full, irq}, 4'b0);
    chk("R1 status", {st_addressed, st_read, st_data, st_ovf}, 4'b0);

    // Address table (R2, R3, R4)
    for (int i = 0; i < 8; i++) begin
      cfg_ten_bit  = VEC[i][19];
      cfg_own_addr = VEC[i][18:9];
      bus_start();
      wr_byte(VEC[i][8:1], a);
      chk($sformatf("R2/R3/R4 vector %0d ack", i), a, VEC[i][0]);
      bus_stop();
    end
    chk("R10 no irq from address-only traffic", irq_cnt, 0);
    chk("R10 rx stays empty", rx_full, 1'b0);

    // 7-bit write, overflow
    cfg_ten_bit = 0; cfg_own_addr = 10'h03A;
    bus_start();
    wr_byte(8'h74, a); chk("R2 ack", a, 1'b1);
    chk("R2 R9 status after addr", {st_addressed, st_read, st_data}, 3'b100);
    wr_byte(8'hA5, a); chk("R5 data ack", a, 1'b1);
    chk("R5 rx_rdata", rx_rdata, 8'hA5);
    chk("R5 rx_full", rx_full, 1'b1);
    chk("R5 irq count", irq_cnt, 1);
    chk("R9 st_data after data", st_data, 1'b1);
    wr_byte(8'h3C, a); chk("R6 nack on full", a, 1'b0);
    chk("R6 ovf set", st_ovf, 1'b1);
    chk("R6 rx kept", rx_rdata, 8'hA5);
    bus_stop();
    chk("R9 stop clears addressed", st_addressed, 1'b0);
    pulse(rx_rd); cyc(1);
    chk("R5 pop clears full", rx_full, 1'b0);
    chk("R6 ovf sticky", st_ovf, 1'b1);
    pulse(ovf_clr); cyc(1);
    chk("R6 ovf cleared", st_ovf, 1'b0);

    // 10-bit write, then repeated-start read
    cfg_ten_bit = 1; cfg_own_addr = 10'h2C5;
    bus_start();
    wr_byte(8'hF4, a); chk("R3 first byte ack", a, 1'b1);
    chk("R3 not yet addressed", st_addressed, 1'b0);
    wr_byte(8'hC5, a); chk("R3 second byte ack", a, 1'b1);
    chk("R3 addressed write", {st_addressed, st_read}, 2'b10);
    wr_byte(8'h81, a); chk("R5 10-bit data ack", a, 1'b1);
    chk("R5 10-bit rx", rx_rdata, 8'h81);
    pulse(rx_rd);
    bus_rstart();
    wr_byte(8'hF5, a); chk("R4 shortcut ack", a, 1'b1);
    chk("R4 addressed read", {st_addressed, st_read, st_data}, 3'b110);
    probe_stretch("R7 stretch after read address");
    release_with(8'h96);
    rd_byte(1'b1, d); chk("R7 first read byte", d, 8'h96);
    chk("R9 st_data after sent byte", st_data, 1'b1);
    probe_stretch("R7 stretch between read bytes");
    release_with(8'h4B);
    rd_byte(1'b0, d); chk("R7 second read byte", d, 8'h4B);
    bus_stop();
    chk("R9 addressed cleared", st_addressed, 1'b0);

    // 10-bit second byte mismatch
    bus_start();
    wr_byte(8'hF4, a); chk("R3 hi ack", a, 1'b1);
    wr_byte(8'hC4, a); chk("R3 low mismatch nack", a, 1'b0);
    chk("R3 not addressed", st_addressed, 1'b0);
    bus_stop();
    // Shortcut is not valid after a stop
    bus_start();
    wr_byte(8'hF5, a); chk("R4 no shortcut after stop", a, 1'b0);
    bus_stop();

    // 7-bit read
    cfg_ten_bit = 0; cfg_own_addr = 10'h03A;
    bus_start();
    wr_byte(8'h75, a); chk("R2 read ack", a, 1'b1);
    chk("R2 st_read", st_read, 1'b1);
    probe_stretch("R7 7-bit stretch");
    release_with(8'hC3);
    rd_byte(1'b0, d); chk("R7 7-bit read byte", d, 8'hC3);
    bus_stop();
    cyc(5);
    chk("R5 R10 total irq", irq_cnt, 2);
    chk("R8 bus idle high", {scl_line, sda_line}, 2'b11);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule